// File: doc/BRIEF.md
# Packet-Boundary Video Source Selector with Stall Timeout

This block picks one of two packetised video streams and forwards it to a single output. Input 0 carries live video. Input 1 carries a locally generated background pattern. Every stream uses a valid/ready handshake and marks each packet with start and end flags. A select input names the wanted source. The block honours a change only between packets, so no frame reaching downstream is ever cut in two.

Live video can stop in the middle of a frame, for example when a cable is pulled. A selector that waited only for an end-of-packet would then hang and stall the whole pipeline. To avoid this, a stall timer runs while a change is pending inside an open packet. If the active source goes a programmed number of cycles without handing over a beat, the block emits a closing beat of its own with the end flag set. It then switches source and raises a sticky flag that reports the forced change.

A newly selected source is joined only at a packet start. While live video is selected, the background input is drained, so it can come in cleanly later.

Top module: `frame_sel_switch`

## Requirements
- R1: During and directly after reset, the output is not valid, the reported source is 0 (live) and the forced flag is 0.
- R2: In an open packet, the active input's valid, data, start flag and end flag appear on the output in the same cycle, and the active input's ready equals the output ready.
- R3: The live input's ready is low whenever the background (source 1) is active. The background input's ready is high whenever live (source 0) is active.
- R4: Outside a packet, a beat from the active input whose start flag is 0 is discarded. Its ready is high, the output is not valid, and output ready has no effect.
- R5: After the select input differs from the active source inside an open packet, the active input keeps being forwarded. The reported source changes at the clock edge where the end-flag beat is accepted downstream.
- R6: A change is pending inside an open packet and the active input transfers no beat for `timeout_i` consecutive cycles. On the next cycle the output presents a beat with valid 1, end flag 1, start flag 0 and data 0, while the active input's ready is low.
- R7: The stall timer counts cycles with the output held by backpressure. The closing beat stays on the output until output ready is high.
- R8: At the edge where the closing beat is accepted, the source switches to the selected one and the forced flag becomes 1.
- R9: Every beat transferred by the active input while a change is pending restarts the stall count from zero.
- R10: The forced flag stays 1 until `clr_forced_i` is high at a clock edge. After that edge it reads 0, unless a closing beat is accepted at the same edge.
- R11: After a switch, beats of the new source are discarded until one with the start flag set arrives. That beat is forwarded with the start flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Requested source: 0 live, 1 background |
| timeout_i | input | 24 | Stall limit in cycles |
| clr_forced_i | input | 1 | Clears the forced-switch flag |
| live_valid_i | input | 1 | Live stream valid |
| live_ready_o | output | 1 | Live stream ready |
| live_sop_i | input | 1 | Live start of packet |
| live_eop_i | input | 1 | Live end of packet |
| live_data_i | input | DATA_W | Live beat data |
| bg_valid_i | input | 1 | Background stream valid |
| bg_ready_o | output | 1 | Background stream ready |
| bg_sop_i | input | 1 | Background start of packet |
| bg_eop_i | input | 1 | Background end of packet |
| bg_data_i | input | DATA_W | Background beat data |
| out_valid_o | output | 1 | Output valid |
| out_ready_i | input | 1 | Output ready from downstream |
| out_sop_o | output | 1 | Output start of packet |
| out_eop_o | output | 1 | Output end of packet |
| out_data_o | output | DATA_W | Output beat data |
| cur_src_o | output | 1 | Source now active |
| forced_o | output | 1 | Sticky flag for a forced switch |

## Verification
The bench changes the select input in the middle of a frame and checks the boundary case. A design that switched at once would splice two frames. One that switched a cycle late would drop or misplace the first beat. It then stalls the background source mid-frame while holding backpressure. A timer that paused under backpressure would never fire and the pipeline would hang. A timer that ignored transfers would force the change too early. The closing beat is held for several cycles, and the bench checks that its end flag, zero data and blocked input ready stay put. It also checks that stray non-start beats after a switch are dropped rather than leaking into the output.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int unsigned N_SRC  = 2;
  localparam int unsigned BG_IDX = 1;
  typedef enum logic {SRC_LIVE = 1'b0, SRC_BG = 1'b1} src_e;
endpackage

// File: rtl/fsw_timer.sv
module fsw_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = run_i && !restart_i && (cnt_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)    cnt_q <= cnt_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/fsw_mux.sv
module fsw_mux
  import fsw_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic [N_SRC-1:0]             valid_i,
  input  logic [N_SRC-1:0]             sop_i,
  input  logic [N_SRC-1:0]             eop_i,
  input  logic [N_SRC-1:0][DATA_W-1:0] data_i,
  output logic [N_SRC-1:0]             ready_o,
  input  src_e                         cur_i,
  input  logic                         in_pkt_i,
  input  logic                         hold_i,
  input  logic                         close_i,
  input  logic                         out_ready_i,
  output logic                         out_valid_o,
  output logic                         out_sop_o,
  output logic                         out_eop_o,
  output logic [DATA_W-1:0]            out_data_o,
  output logic                         act_hs_o
);
  logic act_v, act_sop, act_ready;

  assign act_v   = valid_i[cur_i];
  assign act_sop = sop_i[cur_i];

  always_comb begin
    out_valid_o = 1'b0;
    out_sop_o   = 1'b0;
    out_eop_o   = 1'b0;
    out_data_o  = '0;
    act_ready   = 1'b0;
    if (close_i) begin
      out_valid_o = 1'b1;
      out_eop_o   = 1'b1;
    end else if (hold_i) begin
      act_ready = 1'b0;
    end else if (!in_pkt_i && !act_sop) begin
      act_ready = 1'b1;          // discard stray beat outside a packet
    end else begin
      out_valid_o = act_v;
      out_sop_o   = act_sop;
      out_eop_o   = eop_i[cur_i];
      out_data_o  = data_i[cur_i];
      act_ready   = out_ready_i;
    end
  end

  assign act_hs_o = act_v && act_ready;

  for (genvar i = 0; i < N_SRC; i++) begin : g_rdy
    assign ready_o[i] = (cur_i == src_e'(i)) ? act_ready : (i == BG_IDX);
  end
endmodule

// File: rtl/frame_sel_switch.sv
module frame_sel_switch
  import fsw_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned TMO_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic              clr_forced_i,
  input  logic              live_valid_i,
  output logic              live_ready_o,
  input  logic              live_sop_i,
  input  logic              live_eop_i,
  input  logic [DATA_W-1:0] live_data_i,
  input  logic              bg_valid_i,
  output logic              bg_ready_o,
  input  logic              bg_sop_i,
  input  logic              bg_eop_i,
  input  logic [DATA_W-1:0] bg_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              cur_src_o,
  output logic              forced_o
);
  src_e cur_q;
  logic in_pkt_q, closing_q, forced_q;
  logic pend, hold, fwd_xfer, close_xfer, act_hs, expire;
  logic [N_SRC-1:0] rdy;

  assign pend       = (src_e'(sel_i) != cur_q);
  assign hold       = pend && !in_pkt_q;     // at boundary: switch before forwarding
  assign fwd_xfer   = out_valid_o && out_ready_i && !closing_q;
  assign close_xfer = closing_q && out_ready_i;

  fsw_mux #(.DATA_W(DATA_W)) i_mux (
    .valid_i     ({bg_valid_i, live_valid_i}),
    .sop_i       ({bg_sop_i, live_sop_i}),
    .eop_i       ({bg_eop_i, live_eop_i}),
    .data_i      ({bg_data_i, live_data_i}),
    .ready_o     (rdy),
    .cur_i       (cur_q),
    .in_pkt_i    (in_pkt_q),
    .hold_i      (hold),
    .close_i     (closing_q),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_sop_o   (out_sop_o),
    .out_eop_o   (out_eop_o),
    .out_data_o  (out_data_o),
    .act_hs_o    (act_hs)
  );

  fsw_timer #(.CNT_W(TMO_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (pend && in_pkt_q && !closing_q),
    .restart_i (act_hs),
    .limit_i   (timeout_i),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= SRC_LIVE;
      in_pkt_q  <= 1'b0;
      closing_q <= 1'b0;
      forced_q  <= 1'b0;
    end else begin
      if (close_xfer)    in_pkt_q <= 1'b0;
      else if (fwd_xfer) in_pkt_q <= !out_eop_o;

      if (pend && (!in_pkt_q || (fwd_xfer && out_eop_o) || close_xfer))
        cur_q <= src_e'(sel_i);

      if (close_xfer)  closing_q <= 1'b0;
      else if (expire) closing_q <= 1'b1;

      if (close_xfer)        forced_q <= 1'b1;
      else if (clr_forced_i) forced_q <= 1'b0;
    end
  end

  assign live_ready_o = rdy[0];
  assign bg_ready_o   = rdy[BG_IDX];
  assign cur_src_o    = cur_q;
  assign forced_o     = forced_q;
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cur_src_o,
  input logic live_ready_o,
  input logic bg_ready_o,
  input logic out_valid_o,
  input logic out_ready_i,
  input logic out_eop_o,
  input logic forced_o,
  input logic clr_forced_i,
  input logic in_pkt_q
);
  a_r3_live_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_src_o |-> !live_ready_o);

  a_r3_bg_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_src_o |-> bg_ready_o);

  a_r2_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !(cur_src_o ? bg_ready_o : live_ready_o));

  a_r5_switch_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_src_o) |-> $past(!in_pkt_q || (out_valid_o && out_ready_i && out_eop_o)));

  a_r8_flag_on_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(forced_o) |-> $past(out_valid_o && out_ready_i && out_eop_o));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_forced_i && !(out_valid_o && out_ready_i && out_eop_o)) |=> !forced_o);
endmodule

bind frame_sel_switch fsw_checker i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cur_src_o    (cur_src_o),
  .live_ready_o (live_ready_o),
  .bg_ready_o   (bg_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_eop_o    (out_eop_o),
  .forced_o     (forced_o),
  .clr_forced_i (clr_forced_i),
  .in_pkt_q     (in_pkt_q)
);

// File: tb/test_frame_sel_switch.sv
module test_frame_sel_switch;
  localparam int unsigned DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, clr = 1'b0;
  logic [23:0] tmo = 24'd100;
  logic lv = 1'b0, ls = 1'b0, le = 1'b0;
  logic [DW-1:0] ld = '0;
  logic bv = 1'b0, bs = 1'b0, be = 1'b0;
  logic [DW-1:0] bd = '0;
  logic mr = 1'b0;
  logic lr, br, ov, osop, oeop, cur, frc;
  logic [DW-1:0] od;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_sel_switch i_frame_sel_switch (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .timeout_i(tmo), .clr_forced_i(clr),
    .live_valid_i(lv), .live_ready_o(lr), .live_sop_i(ls), .live_eop_i(le), .live_data_i(ld),
    .bg_valid_i(bv), .bg_ready_o(br), .bg_sop_i(bs), .bg_eop_i(be), .bg_data_i(bd),
    .out_valid_o(ov), .out_ready_i(mr), .out_sop_o(osop), .out_eop_o(oeop), .out_data_o(od),
    .cur_src_o(cur), .forced_o(frc)
  );

  // {valid, sop, eop, out_ready, data[7:0], exp_valid, exp_ready, exp_sop, exp_eop}
  localparam logic [15:0] VEC [8] = '{
    {4'b1001, 8'h11, 4'b0100},
    {4'b1101, 8'h22, 4'b1110},
    {4'b1000, 8'h33, 4'b1000},
    {4'b1001, 8'h33, 4'b1100},
    {4'b0001, 8'h00, 4'b0100},
    {4'b1011, 8'h44, 4'b1101},
    {4'b1111, 8'h55, 4'b1111},
    {4'b1000, 8'h66, 4'b0100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid in reset", 32'(ov), 0);
    chk("R1 src in reset", 32'(cur), 0);
    rst_n = 1'b1;
    step();
    #1;
    chk("R1 valid after reset", 32'(ov), 0);
    chk("R1 src after reset", 32'(cur), 0);
    chk("R1 flag after reset", 32'(frc), 0);

    // R2 R4: live passthrough vectors
    for (int k = 0; k < 8; k++) begin
      {lv, ls, le, mr} = VEC[k][15:12];
      ld = DW'(VEC[k][11:4]);
      #1;
      chk("R2 R4 vec valid", 32'(ov), 32'(VEC[k][3]));
      chk("R2 R4 vec ready", 32'(lr), 32'(VEC[k][2]));
      chk("R2 vec sop", 32'(osop), 32'(VEC[k][1]));
      chk("R2 vec eop", 32'(oeop), 32'(VEC[k][0]));
      if (VEC[k][3]) chk("R2 vec data", 32'(od), 32'(VEC[k][11:4]));
      chk("R3 bg drained", 32'(br), 1);
      step();
    end

    // R5: request mid-packet, switch at end of packet
    {lv, ls, le, mr} = 4'b1101; ld = DW'(8'hA1);
    step();
    sel = 1'b1; {lv, ls, le} = 3'b100; ld = DW'(8'hA2);
    #1;
    chk("R5 still forwarding", 32'(ov), 1);
    chk("R5 data live", 32'(od), 32'hA2);
    chk("R5 src held", 32'(cur), 0);
    step();
    {lv, ls, le} = 3'b101; ld = DW'(8'hA3);
    #1;
    chk("R5 eop forwarded", 32'(oeop), 1);
    chk("R5 src before eop edge", 32'(cur), 0);
    step();
    lv = 1'b0; le = 1'b0;
    #1;
    chk("R5 src after eop edge", 32'(cur), 1);
    chk("R3 live blocked", 32'(lr), 0);

    // R11: join background at start of packet
    {bv, bs, be} = 3'b100; bd = DW'(8'hB0);
    #1;
    chk("R11 stray dropped valid", 32'(ov), 0);
    chk("R11 stray accepted", 32'(br), 1);
    step();
    {bv, bs, be} = 3'b110; bd = DW'(8'hB1);
    #1;
    chk("R11 sop forwarded", 32'(ov), 1);
    chk("R11 sop flag", 32'(osop), 1);
    chk("R11 sop data", 32'(od), 32'hB1);
    step();

    // R6 R7 R9: background stalls mid-frame, forced close
    tmo = 24'd5; sel = 1'b0; bv = 1'b0; bs = 1'b0;
    step();                                   // c0
    step();                                   // c1
    {bv, bs, be} = 3'b100; bd = DW'(8'hB2);   // c2: transfer restarts timer
    step();
    bd = DW'(8'h77); mr = 1'b0;               // c3.. backpressure
    step(); step();                           // c3 c4
    #1;
    chk("R9 no close after restart", 32'(oeop), 0);
    chk("R9 data held", 32'(od), 32'h77);
    step(); step();                           // c5 c6
    #1;
    chk("R7 timer runs in backpressure", 32'(oeop), 0);
    step();                                   // c7
    #1;
    chk("R6 close valid", 32'(ov), 1);
    chk("R6 close eop", 32'(oeop), 1);
    chk("R6 close sop", 32'(osop), 0);
    chk("R6 close data", 32'(od), 0);
    chk("R6 bg blocked", 32'(br), 0);
    chk("R3 live blocked at close", 32'(lr), 0);
    step();                                   // c8
    #1;
    chk("R7 close held", 32'(oeop & ov), 1);
    chk("R7 src held", 32'(cur), 1);
    chk("R8 flag not yet", 32'(frc), 0);
    mr = 1'b1;
    step();
    bv = 1'b0;
    #1;
    chk("R8 switched", 32'(cur), 0);
    chk("R8 flag set", 32'(frc), 1);
    chk("R3 bg drained after", 32'(br), 1);
    step();
    #1;
    chk("R10 flag sticky", 32'(frc), 1);
    clr = 1'b1;
    step();
    clr = 1'b0;
    #1;
    chk("R10 flag cleared", 32'(frc), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule